// File: doc/BRIEF.md
# Oscillator Alarm Supervisor

This block watches a bank of free-running entropy oscillator channels. Each channel raises a one-cycle alarm pulse whenever its own sample checks flag a bad result. Every enabled, unmasked channel keeps an alarm counter. When the count passes a programmable threshold, the channel is stopped on the spot: its enable bit drops and a bit in a stopped-channel record is set. Software reads that record later to decide how to recover.

The first stop since the last acknowledge is logged without any flag. A second stop raises a sticky shutdown-overflow flag. The flag stays set until software acknowledges it. Software reaches the enable, detune, mask, stop-record, threshold and status words through one simple word-wide register port. Channel count and counter width are parameters. A word on the port is as wide as the channel bank.

Top module: `osc_sup_top`

## Requirements
- R1: After a synchronous reset, the enable, detune, mask and stop-record words are zero, the threshold is all ones, the escalation tally is zero and `shutdown_ovf_o` is low.
- R2: Register offsets on `reg_addr` are: 0x00 threshold (low CNT_W bits), 0x04 enable, 0x08 detune, 0x0C mask and 0x10 stop record. 0x14 is status, with bit 0 the overflow flag and bits 2:1 the tally. Reads are combinational on `reg_addr`, and any other offset reads zero. `osc_en_o` and `osc_detune_o` always show the enable and detune words.
- R3: An alarm on an enabled, unmasked channel whose count is below the threshold adds one to the count. An alarm that arrives while the count is at or above the threshold trips the channel. With a threshold of 0, the first alarm trips, and lowering the threshold below a running count makes the next alarm trip.
- R4: On the edge after a trip, the channel's enable bit is 0, its stop-record bit is 1 and its count is back to 0.
- R5: A channel whose enable bit is 0 holds a count of zero and ignores its alarms.
- R6: A channel whose mask bit is 1 ignores its alarms. Its count holds, and it never trips.
- R7: The stop events since the last acknowledge form a tally that saturates at 2, and each tripping channel counts as one event. A tally of 1 leaves `shutdown_ovf_o` low.
- R8: When the tally reaches 2, `shutdown_ovf_o` rises on that edge, including when two channels trip in the same cycle. It stays high until acknowledged.
- R9: A status write with bit 0 set acknowledges: it clears the flag and the tally before counting any trips of that same cycle. A status write with bit 0 clear changes nothing.
- R10: Writing the enable word clears the stop-record bit of every channel written as 1. Writing the stop-record word replaces it. A trip in the same cycle as either write wins for its channel: that channel's enable bit ends at 0 and its stop bit at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset for both read and write |
| reg_wdata | input | NUM_CH | Write data |
| reg_rdata | output | NUM_CH | Read data for `reg_addr` |
| alarm_i | input | NUM_CH | Per-channel alarm pulses |
| osc_en_o | output | NUM_CH | Per-channel oscillator run enables |
| osc_detune_o | output | NUM_CH | Per-channel detune controls |
| shutdown_ovf_o | output | 1 | Sticky second-stop flag |

## Verification
The bench builds the block with 8 channels and a 3-bit counter, not the default 32 and 8. With these values a trip takes only a few alarm pulses, and every channel can be used up within one short run. The small bank also makes it practical to set up cases that would take hundreds of pulses at the default width. These are a threshold of zero, a threshold lowered below a running count, two trips in one cycle, an acknowledge that lands in the same cycle as a trip, and an enable write that collides with a trip.

// File: rtl/osc_sup_pkg.sv
package osc_sup_pkg;

    localparam int ADDR_W = 5;

    typedef enum logic [ADDR_W-1:0] {
        RA_THR  = 5'h00,
        RA_EN   = 5'h04,
        RA_DET  = 5'h08,
        RA_MASK = 5'h0C,
        RA_STOP = 5'h10,
        RA_STAT = 5'h14
    } reg_addr_e;

    localparam int unsigned TALLY_SAT = 2;

    typedef struct packed {
        logic [1:0] tally;
        logic       ovf;
    } esc_state_t;

    function automatic logic [1:0] tally_add(input int unsigned base, input int unsigned add);
        int unsigned s;
        s = base + add;
        if (s > TALLY_SAT) s = TALLY_SAT;
        return 2'(s);
    endfunction

endpackage

// File: rtl/osc_sup_chan.sv
module osc_sup_chan #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alarm_i,
    input  logic             enabled_i,
    input  logic             masked_i,
    input  logic [CNT_W-1:0] thr_i,
    output logic             trip_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             hit;

    // an alarm only counts on a running, unmasked channel
    assign hit    = alarm_i & enabled_i & ~masked_i;
    assign trip_o = hit && (cnt_q >= thr_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!enabled_i || trip_o) begin
            cnt_q <= '0;
        end else if (hit) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/osc_sup_regs.sv
module osc_sup_regs
    import osc_sup_pkg::*;
#(
    parameter int NUM_CH = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [NUM_CH-1:0] wdata_i,
    input  logic [NUM_CH-1:0] trip_i,
    input  esc_state_t        esc_i,
    output logic [CNT_W-1:0]  thr_o,
    output logic [NUM_CH-1:0] en_o,
    output logic [NUM_CH-1:0] det_o,
    output logic [NUM_CH-1:0] mask_o,
    output logic [NUM_CH-1:0] stop_o,
    output logic [NUM_CH-1:0] rdata_o,
    output logic              ack_o
);
    logic [CNT_W-1:0]  thr_q;
    logic [NUM_CH-1:0] en_q, det_q, mask_q, stop_q;
    logic [NUM_CH-1:0] en_d, stop_d;
    logic              wr_en, wr_stop;

    assign wr_en   = wr_i && (addr_i == RA_EN);
    assign wr_stop = wr_i && (addr_i == RA_STOP);
    assign ack_o   = wr_i && (addr_i == RA_STAT) && wdata_i[0];

    // software writes first, hardware trips override per channel
    always_comb begin
        en_d   = wr_en ? wdata_i : en_q;
        stop_d = stop_q;
        if (wr_en)   stop_d = stop_q & ~wdata_i;
        if (wr_stop) stop_d = wdata_i;
        en_d   = en_d & ~trip_i;
        stop_d = stop_d | trip_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q  <= '1;
            en_q   <= '0;
            det_q  <= '0;
            mask_q <= '0;
            stop_q <= '0;
        end else begin
            en_q   <= en_d;
            stop_q <= stop_d;
            if (wr_i && addr_i == RA_THR)  thr_q  <= wdata_i[CNT_W-1:0];
            if (wr_i && addr_i == RA_DET)  det_q  <= wdata_i;
            if (wr_i && addr_i == RA_MASK) mask_q <= wdata_i;
        end
    end

    always_comb begin
        case (addr_i)
            RA_THR:  rdata_o = NUM_CH'(thr_q);
            RA_EN:   rdata_o = en_q;
            RA_DET:  rdata_o = det_q;
            RA_MASK: rdata_o = mask_q;
            RA_STOP: rdata_o = stop_q;
            RA_STAT: rdata_o = NUM_CH'(esc_i);
            default: rdata_o = '0;
        endcase
    end

    assign thr_o  = thr_q;
    assign en_o   = en_q;
    assign det_o  = det_q;
    assign mask_o = mask_q;
    assign stop_o = stop_q;

endmodule

// File: rtl/osc_sup_esc.sv
module osc_sup_esc
    import osc_sup_pkg::*;
#(
    parameter int NUM_CH = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] trip_i,
    input  logic              ack_i,
    output esc_state_t        esc_o,
    output logic              ovf_o
);
    localparam int EVT_W = $clog2(NUM_CH + 1);

    logic [EVT_W-1:0] evt;
    logic [1:0]       base, tally_d, tally_q;
    logic             ovf_q, ovf_d;

    always_comb begin
        evt = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            evt = evt + EVT_W'(trip_i[i]);
        end
    end

    // acknowledge is applied before the events of the same cycle
    always_comb begin
        base    = ack_i ? 2'd0 : tally_q;
        tally_d = tally_add(32'(base), 32'(evt));
        ovf_d   = ((ack_i ? 1'b0 : ovf_q) | (32'(tally_d) == TALLY_SAT));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tally_q <= '0;
            ovf_q   <= 1'b0;
        end else begin
            tally_q <= tally_d;
            ovf_q   <= ovf_d;
        end
    end

    assign esc_o.tally = tally_q;
    assign esc_o.ovf   = ovf_q;
    assign ovf_o       = ovf_q;

endmodule

// File: rtl/osc_sup_top.sv
module osc_sup_top
    import osc_sup_pkg::*;
#(
    parameter int NUM_CH = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [NUM_CH-1:0] reg_wdata,
    output logic [NUM_CH-1:0] reg_rdata,
    input  logic [NUM_CH-1:0] alarm_i,
    output logic [NUM_CH-1:0] osc_en_o,
    output logic [NUM_CH-1:0] osc_detune_o,
    output logic              shutdown_ovf_o
);
    logic [CNT_W-1:0]  thr_w;
    logic [NUM_CH-1:0] en_w, mask_w, stop_w, trip_w;
    logic              ack_w;
    esc_state_t        esc_w;

    osc_sup_regs #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_i   (reg_wr),
        .addr_i (reg_addr),
        .wdata_i(reg_wdata),
        .trip_i (trip_w),
        .esc_i  (esc_w),
        .thr_o  (thr_w),
        .en_o   (en_w),
        .det_o  (osc_detune_o),
        .mask_o (mask_w),
        .stop_o (stop_w),
        .rdata_o(reg_rdata),
        .ack_o  (ack_w)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        osc_sup_chan #(.CNT_W(CNT_W)) u_chan (
            .clk      (clk),
            .rst      (rst),
            .alarm_i  (alarm_i[g]),
            .enabled_i(en_w[g]),
            .masked_i (mask_w[g]),
            .thr_i    (thr_w),
            .trip_o   (trip_w[g])
        );
    end

    osc_sup_esc #(.NUM_CH(NUM_CH)) u_esc (
        .clk   (clk),
        .rst   (rst),
        .trip_i(trip_w),
        .ack_i (ack_w),
        .esc_o (esc_w),
        .ovf_o (shutdown_ovf_o)
    );

    assign osc_en_o = en_w;

endmodule

// File: rtl/osc_sup_chk.sv
module osc_sup_chk #(
    parameter int NUM_CH = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_CH-1:0] trip,
    input logic [NUM_CH-1:0] en,
    input logic [NUM_CH-1:0] stop,
    input logic [NUM_CH-1:0] mask,
    input logic              ovf,
    input logic              ack
);
    AST_TRIP_DISABLES: assert property (@(posedge clk) disable iff (rst)
        (trip != '0) |=> ((en & $past(trip)) == '0)); // R4

    AST_TRIP_RECORDED: assert property (@(posedge clk) disable iff (rst)
        (trip != '0) |=> ((stop & $past(trip)) == $past(trip))); // R4

    AST_DISABLED_NO_TRIP: assert property (@(posedge clk) disable iff (rst)
        ((trip & ~en) == '0)); // R5

    AST_MASKED_NO_TRIP: assert property (@(posedge clk) disable iff (rst)
        ((trip & mask) == '0)); // R6

    AST_OVF_NEEDS_TRIP: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf) |-> ($past(trip) != '0)); // R8

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovf && !ack) |=> ovf); // R8

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (ack && trip == '0) |=> !ovf); // R9

endmodule

bind osc_sup_top osc_sup_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk (clk),
    .rst (rst),
    .trip(trip_w),
    .en  (en_w),
    .stop(stop_w),
    .mask(mask_w),
    .ovf (shutdown_ovf_o),
    .ack (ack_w)
);

// File: tb/sim_osc_sup_top.sv
`timescale 1ns/1ps
module sim_osc_sup_top;
    localparam int N  = 8;
    localparam int CW = 3;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         reg_wr = 1'b0;
    logic [4:0]   reg_addr = 5'h00;
    logic [N-1:0] reg_wdata = '0;
    logic [N-1:0] reg_rdata;
    logic [N-1:0] alarm_i = '0;
    logic [N-1:0] osc_en_o, osc_detune_o;
    logic         shutdown_ovf_o;

    always #2.5 clk = ~clk;

    osc_sup_top #(.NUM_CH(N), .CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .alarm_i(alarm_i),
        .osc_en_o(osc_en_o), .osc_detune_o(osc_detune_o),
        .shutdown_ovf_o(shutdown_ovf_o)
    );

    // behavioural reference state
    int           cnt [N];
    logic [N-1:0] m_en, m_det, m_mask, m_stop;
    int           m_thr;
    int           m_tally;
    int           n_chk = 0;
    int           n_err = 0;

    localparam logic [4:0] A_THR = 5'h00, A_EN = 5'h04, A_DET = 5'h08,
                           A_MASK = 5'h0C, A_STOP = 5'h10, A_STAT = 5'h14;

    task automatic model_reset();
        for (int i = 0; i < N; i++) cnt[i] = 0;
        m_en = '0; m_det = '0; m_mask = '0; m_stop = '0;
        m_thr = (1 << CW) - 1;
        m_tally = 0;
    endtask

    task automatic model_step(input logic wr, input logic [4:0] a, input logic [N-1:0] wd,
                              input logic [N-1:0] al);
        logic [N-1:0] tr;
        int           ntr;
        int           base;
        tr  = '0;
        ntr = 0;
        for (int i = 0; i < N; i++) begin
            if (al[i] && m_en[i] && !m_mask[i]) begin
                if (cnt[i] >= m_thr) begin
                    tr[i] = 1'b1;
                    ntr++;
                    cnt[i] = 0;
                end else begin
                    cnt[i] = cnt[i] + 1;
                end
            end
            if (!m_en[i]) cnt[i] = 0;
        end
        base = (wr && a == A_STAT && wd[0]) ? 0 : m_tally;
        if (wr) begin
            case (a)
                A_THR:  m_thr = int'(wd) % (1 << CW);
                A_EN:   begin m_en = wd; m_stop = m_stop & ~wd; end
                A_DET:  m_det = wd;
                A_MASK: m_mask = wd;
                A_STOP: m_stop = wd;
                default: ;
            endcase
        end
        m_en    = m_en & ~tr;
        m_stop  = m_stop | tr;
        m_tally = (base + ntr > 2) ? 2 : base + ntr;
    endtask

    function automatic logic [N-1:0] model_read(input logic [4:0] a);
        case (a)
            A_THR:  return N'(m_thr);
            A_EN:   return m_en;
            A_DET:  return m_det;
            A_MASK: return m_mask;
            A_STOP: return m_stop;
            A_STAT: return N'({2'(m_tally), m_tally == 2});
            default: return '0;
        endcase
    endfunction

    task automatic chk(input string what, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        chk("osc_en_o", tag, 32'(osc_en_o), 32'(m_en));
        chk("osc_detune_o", tag, 32'(osc_detune_o), 32'(m_det));
        chk("shutdown_ovf_o", tag, 32'(shutdown_ovf_o), 32'(m_tally == 2));
        chk("reg_rdata", tag, 32'(reg_rdata), 32'(model_read(reg_addr)));
    endtask

    task automatic tick(input logic wr, input logic [4:0] a, input logic [N-1:0] wd,
                        input logic [N-1:0] al, input string tag);
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = wd; alarm_i = al;
        model_step(wr, a, wd, al);
        @(posedge clk);
        #1;
        compare(tag);
    endtask

    task automatic rd(input logic [4:0] a, input string tag);
        tick(1'b0, a, '0, '0, tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #0.5;
        compare("R1");
        // R1: reset values read back
        rd(A_THR, "R1"); rd(A_EN, "R1"); rd(A_DET, "R1");
        rd(A_MASK, "R1"); rd(A_STOP, "R1"); rd(A_STAT, "R1");
        // R2: register map and readback
        tick(1, A_THR, 8'h02, '0, "R2");
        tick(1, A_DET, 8'hA5, '0, "R2");
        tick(1, A_EN, 8'hFF, '0, "R2");
        rd(A_THR, "R2"); rd(A_DET, "R2"); rd(A_EN, "R2"); rd(5'h18, "R2");
        // R3/R4/R7: channel 0 trips on third alarm with threshold 2
        tick(0, A_STOP, '0, 8'h01, "R3");
        tick(0, A_STOP, '0, 8'h01, "R3");
        tick(0, A_STOP, '0, 8'h01, "R4");
        rd(A_STAT, "R7"); rd(A_STOP, "R4");
        // R6: masked channel 1 never trips
        tick(1, A_MASK, 8'h02, '0, "R6");
        for (int k = 0; k < 5; k++) tick(0, A_STOP, '0, 8'h02, "R6");
        // R5: disabled channel 2 ignores alarms
        tick(1, A_EN, 8'hFA, '0, "R5");
        for (int k = 0; k < 4; k++) tick(0, A_STOP, '0, 8'h04, "R5");
        tick(1, A_EN, m_en | 8'h04, '0, "R5");
        tick(0, A_STOP, '0, 8'h04, "R5");
        // R8: second stop raises overflow and holds
        for (int k = 0; k < 3; k++) tick(0, A_STAT, '0, 8'h08, "R8");
        for (int k = 0; k < 3; k++) rd(A_STAT, "R8");
        // R9: status write without bit 0 does nothing; with bit 0 acknowledges
        tick(1, A_STAT, 8'h06, '0, "R9");
        tick(1, A_STAT, 8'h01, '0, "R9");
        rd(A_STAT, "R9");
        // R10: enable write clears stop bit; stop write replaces record
        tick(1, A_EN, m_en | 8'h01, '0, "R10");
        rd(A_STOP, "R10");
        tick(1, A_STOP, 8'h00, '0, "R10");
        rd(A_STOP, "R10");
        // R3: threshold lowered below running count
        tick(0, A_STOP, '0, 8'h10, "R3");
        tick(0, A_STOP, '0, 8'h10, "R3");
        tick(1, A_THR, 8'h01, '0, "R3");
        tick(0, A_STOP, '0, 8'h10, "R3");
        rd(A_STAT, "R7");
        // R8: two trips in one cycle at threshold 0
        tick(1, A_STAT, 8'h01, '0, "R9");
        tick(1, A_THR, 8'h00, '0, "R3");
        tick(0, A_STAT, '0, 8'h60, "R8");
        rd(A_STOP, "R8");
        // R9: acknowledge and trip in the same cycle
        tick(1, A_STAT, 8'h01, 8'h01, "R9");
        rd(A_STAT, "R9");
        // R10: trip wins over a colliding enable write
        tick(1, A_THR, 8'h01, '0, "R10");
        tick(0, A_STOP, '0, 8'h80, "R10");
        tick(1, A_EN, m_en | 8'h80, 8'h80, "R10");
        rd(A_STOP, "R10"); rd(A_EN, "R10");
        // R6: all masked, nothing changes
        tick(1, A_MASK, 8'hFF, '0, "R6");
        for (int k = 0; k < 4; k++) tick(0, A_EN, '0, 8'hFF, "R6");
        rd(A_STAT, "R6");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule